// File: doc/BRIEF.md
# USB OUT Endpoint Transfer Tracker

This block holds the running state of one USB device OUT endpoint whose received packets pass through a receive FIFO and are then written to system memory by a DMA engine. Software loads a byte budget, a packet budget, a word-aligned start address, an endpoint kind (isochronous or control) and a 2-bit mode code in one configuration write. That write arms the endpoint. While the endpoint is armed, the block counts packets as they land in the FIFO and counts bytes as they are drained to memory. It advances the memory write pointer one 32-bit word per bus beat. When the transfer ends, it disarms itself and pulses a completion flag.

The 2-bit code has a different meaning for each endpoint kind. On an isochronous endpoint it is overwritten with the data PID of each arriving packet. The codes are 0 for DATA0, 1 for DATA2, 2 for DATA1 and 3 for MDATA. On a control endpoint it keeps the programmed number of SETUP packets that may arrive back to back. When one more SETUP packet arrives than that number allows, the block pulses an overwrite flag and moves the write pointer back to the start address, so the new SETUP data replaces the stored copy.

Top module: `usb_out_ep_tracker`

## Requirements
- R1: After reset, `active`, `pkt_left`, `size_left`, `dma_addr`, `ep_code`, `setup_left`, `xfer_done` and `setup_ovr` are all zero.
- R2: A `cfg_we` pulse while idle, with `cfg_addr[1:0]` equal to 0, loads the size, packet count, address, kind and code and sets `active` on the next cycle. A pulse with nonzero `cfg_addr[1:0]` changes nothing.
- R3: A `cfg_we` pulse while `active` is 1 is ignored.
- R4: Each `rx_pkt` pulse while active lowers `pkt_left` by one. At zero, `pkt_left` stays at zero.
- R5: Each `dma_beat` pulse while active adds 4 to `dma_addr`. `dma_addr[1:0]` is always 0.
- R6: Each `drain` pulse lowers `size_left` by `drain_bytes`, stopping at zero. When `size_left` reaches zero, `xfer_done` pulses for one cycle and `active` clears, both on the next cycle.
- R7: A drained packet shorter than MPS (64 bytes by default) also ends the transfer with `xfer_done`, even if `size_left` is still above zero. A size equal to MPS therefore gives one completion per packet.
- R8: On an isochronous endpoint (`cfg_ctrl`=0), each `rx_pkt` copies `rx_pid` into `ep_code`. The codes are 0=DATA0, 1=DATA2, 2=DATA1, 3=MDATA.
- R9: On a control endpoint (`cfg_ctrl`=1), `setup_left` starts at the programmed code and each SETUP packet (`rx_setup`=1) lowers it by one. A SETUP packet that arrives when `setup_left` is 0 pulses `setup_ovr` and sets `dma_addr` back to the start address. This takes priority over a beat in the same cycle.
- R10: On a control endpoint, a non-SETUP packet reloads `setup_left` from `ep_code`.
- R11: While idle, `rx_pkt`, `drain` and `dma_beat` have no effect on `pkt_left`, `size_left` or `dma_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctrl | input | 1 | Endpoint kind: 1 control, 0 isochronous |
| cfg_code | input | 2 | Mode code (SETUP allowance for control) |
| cfg_size | input | SIZE_W | Transfer size in bytes |
| cfg_pkts | input | PKT_W | Packet count |
| cfg_addr | input | ADDR_W | Start address, word aligned |
| rx_pkt | input | 1 | A packet finished entering the FIFO |
| rx_setup | input | 1 | That packet is a SETUP packet |
| rx_pid | input | 2 | Data PID code of that packet |
| drain | input | 1 | A packet finished draining to memory |
| drain_bytes | input | BYTE_W | Byte count of the drained packet |
| dma_beat | input | 1 | One 32-bit bus write completed |
| active | output | 1 | Endpoint armed |
| ctrl | output | 1 | Latched endpoint kind |
| ep_code | output | 2 | Last PID code or SETUP allowance |
| pkt_left | output | PKT_W | Packets remaining |
| size_left | output | SIZE_W | Bytes remaining |
| dma_addr | output | ADDR_W | Current write address |
| setup_left | output | 2 | SETUP packets still accepted |
| setup_ovr | output | 1 | SETUP overwrite pulse |
| xfer_done | output | 1 | Transfer-complete pulse |

## Verification
Every counter in this block is a port, so a wrong internal state shows up at the ports one clock edge after the pulse that caused it. A byte counter that wraps would leave `active` set with a huge `size_left` and no `xfer_done`. A wrong allowance would make `setup_ovr` and the address rewind appear one SETUP packet early or late. A latched kind or code error would change `ep_code` on the next received packet. The bench therefore samples each output one cycle after each stimulus pulse.

// File: rtl/usb_out_ep_tracker.sv
module usb_out_ep_tracker #(
  parameter int SIZE_W = 19,
  parameter int PKT_W  = 10,
  parameter int ADDR_W = 32,
  parameter int MPS    = 64,
  parameter int BYTE_W = $clog2(MPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ctrl,
  input  logic [1:0]        cfg_code,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [PKT_W-1:0]  cfg_pkts,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              rx_pkt,
  input  logic              rx_setup,
  input  logic [1:0]        rx_pid,
  input  logic              drain,
  input  logic [BYTE_W-1:0] drain_bytes,
  input  logic              dma_beat,
  output logic              active,
  output logic              ctrl,
  output logic [1:0]        ep_code,
  output logic [PKT_W-1:0]  pkt_left,
  output logic [SIZE_W-1:0] size_left,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [1:0]        setup_left,
  output logic              setup_ovr,
  output logic              xfer_done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] base;
  logic [SIZE_W-1:0] dbytes;
  logic load, exhaust, short_pkt, finish, rewind;

  assign dbytes    = SIZE_W'(drain_bytes);
  assign load      = cfg_we && !active && (cfg_addr[1:0] == 2'b00);
  assign exhaust   = dbytes >= size_left;
  assign short_pkt = drain_bytes < BYTE_W'(MPS);
  assign finish    = active && drain && (exhaust || short_pkt);
  assign rewind    = active && ctrl && rx_pkt && rx_setup && (setup_left == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      ctrl       <= 1'b0;
      ep_code    <= 2'd0;
      pkt_left   <= '0;
      size_left  <= '0;
      dma_addr   <= '0;
      base       <= '0;
      setup_left <= 2'd0;
      setup_ovr  <= 1'b0;
      xfer_done  <= 1'b0;
    end else begin
      setup_ovr <= 1'b0;
      xfer_done <= 1'b0;
      if (load) begin
        active     <= 1'b1;
        ctrl       <= cfg_ctrl;
        ep_code    <= cfg_code;
        pkt_left   <= cfg_pkts;
        size_left  <= cfg_size;
        dma_addr   <= cfg_addr;
        base       <= cfg_addr;
        setup_left <= cfg_code;
      end else if (active) begin
        if (rx_pkt) begin
          if (pkt_left != '0) pkt_left <= pkt_left - 1'b1;
          if (!ctrl) ep_code <= rx_pid;
          else if (!rx_setup) setup_left <= ep_code;
          else if (setup_left != 2'd0) setup_left <= setup_left - 2'd1;
          else setup_ovr <= 1'b1;
        end
        if (rewind) dma_addr <= base;
        else if (dma_beat) dma_addr <= dma_addr + STEP;
        if (drain) size_left <= exhaust ? '0 : size_left - dbytes;
        if (finish) begin
          active    <= 1'b0;
          xfer_done <= 1'b1;
        end
      end
    end
  end

  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_addr[1:0] == 2'b00);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !active);

  p_pkt_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pkt_left == '0 && rx_pkt) |=> pkt_left == '0);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cfg_we) |=> ($stable(pkt_left) && $stable(size_left) && $stable(dma_addr)));

  p_ovr_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ovr |-> dma_addr == base);

  p_busy_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg_we && !rx_pkt && !drain && !dma_beat) |=> $stable(base) && $stable(ctrl));
endmodule

// File: tb/tb_usb_out_ep_tracker.sv
module tb_usb_out_ep_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_ctrl = 0, rx_pkt = 0, rx_setup = 0, drain = 0, dma_beat = 0;
  logic [1:0] cfg_code = 0, rx_pid = 0;
  logic [18:0] cfg_size = 0;
  logic [9:0] cfg_pkts = 0;
  logic [31:0] cfg_addr = 0;
  logic [6:0] drain_bytes = 0;
  logic active, ctrl, setup_ovr, xfer_done;
  logic [1:0] ep_code, setup_left;
  logic [9:0] pkt_left;
  logic [18:0] size_left;
  logic [31:0] dma_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb_out_ep_tracker dut (.*);

  // {drain bytes, expected size_left, expected xfer_done}
  localparam logic [26:0] VEC [4] = '{
    {7'd64, 19'd136, 1'b0},
    {7'd64, 19'd72,  1'b0},
    {7'd64, 19'd8,   1'b0},
    {7'd8,  19'd0,   1'b1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic c, logic [1:0] code, logic [18:0] sz, logic [9:0] pk, logic [31:0] ad);
    @(negedge clk);
    cfg_we = 1; cfg_ctrl = c; cfg_code = code; cfg_size = sz; cfg_pkts = pk; cfg_addr = ad;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic pkt(logic s, logic [1:0] pid);
    @(negedge clk);
    rx_pkt = 1; rx_setup = s; rx_pid = pid;
    @(posedge clk); #1 rx_pkt = 0; rx_setup = 0;
  endtask

  task automatic drn(logic [6:0] b);
    @(negedge clk);
    drain = 1; drain_bytes = b;
    @(posedge clk); #1 drain = 0;
  endtask

  task automatic beat();
    @(negedge clk);
    dma_beat = 1;
    @(posedge clk); #1 dma_beat = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    chk("R1 active", active, 0);
    chk("R1 pkt_left", pkt_left, 0);
    chk("R1 size_left", size_left, 0);
    chk("R1 addr", dma_addr, 0);
    chk("R1 code", {setup_left, ep_code, setup_ovr, xfer_done}, 0);

    cfg(0, 0, 200, 2, 32'h1002);
    chk("R2 misaligned rejected", active, 0);
    cfg(0, 0, 200, 2, 32'h1000);
    chk("R2 active", active, 1);
    chk("R2 size", size_left, 200);
    chk("R2 pkts", pkt_left, 2);
    chk("R2 addr", dma_addr, 32'h1000);
    cfg(0, 0, 5, 9, 32'h3000);
    chk("R3 size kept", size_left, 200);
    chk("R3 addr kept", dma_addr, 32'h1000);

    pkt(0, 1);
    chk("R4 pkt dec", pkt_left, 1);
    chk("R8 pid DATA2", ep_code, 1);
    pkt(0, 3);
    chk("R8 pid MDATA", ep_code, 3);
    pkt(0, 2);
    chk("R4 pkt floor", pkt_left, 0);
    chk("R8 pid DATA1", ep_code, 2);

    for (int i = 0; i < 3; i++) beat();
    chk("R5 addr step", dma_addr, 32'h100C);

    for (int i = 0; i < 4; i++) begin
      drn(VEC[i][26:20]);
      chk("R6 size_left", size_left, VEC[i][19:1]);
      chk("R6 xfer_done", xfer_done, VEC[i][0]);
    end
    chk("R6 inactive after done", active, 0);

    pkt(0, 1); drn(7'd10); beat();
    chk("R11 pkt idle", pkt_left, 0);
    chk("R11 size idle", size_left, 0);
    chk("R11 addr idle", dma_addr, 32'h100C);

    cfg(0, 0, 300, 5, 32'h4000);
    drn(7'd20);
    chk("R7 short done", xfer_done, 1);
    chk("R7 short size", size_left, 280);
    chk("R7 short idle", active, 0);
    cfg(0, 0, 64, 1, 32'h4000);
    drn(7'd64);
    chk("R7 mps done", xfer_done, 1);
    chk("R7 mps size", size_left, 0);

    cfg(1, 2, 500, 8, 32'h2000);
    chk("R9 allowance", setup_left, 2);
    beat();
    chk("R5 ctrl beat", dma_addr, 32'h2004);
    pkt(1, 0);
    chk("R9 setup 1", setup_left, 1);
    pkt(1, 0);
    chk("R9 setup 2", {setup_left, setup_ovr}, 0);
    @(negedge clk);
    rx_pkt = 1; rx_setup = 1; dma_beat = 1;
    @(posedge clk); #1 rx_pkt = 0; rx_setup = 0; dma_beat = 0;
    chk("R9 overwrite", setup_ovr, 1);
    chk("R9 rewind", dma_addr, 32'h2000);
    chk("R9 code kept", ep_code, 2);
    pkt(0, 1);
    chk("R10 reload", setup_left, 2);
    chk("R10 no ovr", setup_ovr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule